// File: doc/BRIEF.md
# Synchronous BCD Decade Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit value that steps through 0 to 9 in 8421 BCD and wraps from 9 back to 0. Every change happens on the rising clock edge. Four control inputs select the action at each edge, in a fixed order of priority:

- an active-low clear,
- an active-low parallel load from a 4-bit data input,
- counting, which needs two active-high enables,
- hold, which applies otherwise.

Of the two count enables, one is local to the stage and the other is meant to be chained between stages. A combinational carry output goes high when the stage holds 9 and its chained enable is high. Connecting one stage's carry output to the next stage's chained enable builds a multi-digit decimal counter. The six non-BCD codes (10 to 15) can appear after a load or at power-up. The stage has a fixed counting path out of each of them, so it is back in the 0 to 9 range within two counting edges.

Top module: `bcd_decade_stage`

## Requirements
- R1: While counting, a value of 0 to 8 advances by one on each rising edge, and 9 advances to 0.
- R2: When clr_n is low at a rising edge, count_q becomes 0, whatever the load, data and enable inputs are.
- R3: When clr_n is high and load_n is low at a rising edge, count_q takes the value of data_in (any of the 16 codes), whatever the enables are.
- R4: With clr_n and load_n both high, the stage counts only if cnt_en_par and cnt_en_chain are both high. Otherwise count_q keeps its value.
- R5: carry_out is combinational and high exactly when cnt_en_chain is high and count_q equals 9. It does not depend on cnt_en_par, clr_n or load_n.
- R6: carry_out stays low in every code from 10 to 15, including 11, 13 and 15, which have both bit 0 and bit 3 set.
- R7: Counting from a non-BCD code follows 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2, so the stage reaches 0 to 9 within two counting edges. Clear and load behave normally in these codes.
- R8: Two stages form a counter from 00 to 99 when they share the clock, clear, load and cnt_en_par, and the low stage's carry_out drives the high stage's cnt_en_chain. The pair wraps from 99 to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | 4 | Value captured on a load |
| cnt_en_par | input | 1 | Local count enable, active high |
| cnt_en_chain | input | 1 | Chained count enable, active high; also gates carry_out |
| count_q | output | 4 | Current digit value |
| carry_out | output | 1 | High when count_q is 9 and cnt_en_chain is high |

## Verification
The assertions take two things for granted. First, every control and data input is a defined 0 or 1 at each rising edge. Second, clr_n is low at the first edge, so the digit has a known value before any property about counting, loading or holding is evaluated. The bench meets both conditions: it holds clr_n low from time zero, and it drives all inputs at falling edges from known values. Random stimulus is weighted so that clear and load are rare and both enables are usually high. This lets counting runs reach 9 and wrap, while loads still place both stages in all sixteen codes, including the non-BCD ones.

// File: rtl/bcd_stage_pkg.sv
package bcd_stage_pkg;

  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned LAST_DIGIT = 9;
  localparam int unsigned MODE_COUNT_N = 4;

  // Actions in priority order
  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_COUNT = 2'd2,
    ACT_HOLD  = 2'd3
  } act_t;

  // Counting successor, including the exits from non-BCD codes
  function automatic logic [DIGIT_W-1:0] bcd_advance(input logic [DIGIT_W-1:0] cur);
    logic [DIGIT_W-1:0] nxt;
    case (cur)
      4'd9:    nxt = 4'd0;
      4'd11:   nxt = 4'd6;
      4'd13:   nxt = 4'd4;
      4'd15:   nxt = 4'd2;
      default: nxt = cur + 4'd1;
    endcase
    return nxt;
  endfunction

  function automatic logic digit_is_last(input logic [DIGIT_W-1:0] cur);
    return (cur == DIGIT_W'(LAST_DIGIT));
  endfunction

endpackage

// File: rtl/bcd_action_sel.sv
module bcd_action_sel
  import bcd_stage_pkg::*;
(
  input  logic                     clr_n,
  input  logic                     load_n,
  input  logic                     cnt_en_par,
  input  logic                     cnt_en_chain,
  output act_t                     act,
  output logic [MODE_COUNT_N-1:0]  act_vec
);

  logic both_en;
  assign both_en = cnt_en_par & cnt_en_chain;

  always_comb begin
    if (!clr_n)        act = ACT_CLEAR;
    else if (!load_n)  act = ACT_LOAD;
    else if (both_en)  act = ACT_COUNT;
    else               act = ACT_HOLD;
  end

  // One-hot view of the chosen action, built from the raw inputs
  assign act_vec[0] = ~clr_n;
  assign act_vec[1] =  clr_n & ~load_n;
  assign act_vec[2] =  clr_n &  load_n &  both_en;
  assign act_vec[3] =  clr_n &  load_n & ~both_en;

endmodule

// File: rtl/bcd_next_digit.sv
module bcd_next_digit
  import bcd_stage_pkg::*;
(
  input  act_t                act,
  input  logic [DIGIT_W-1:0]  cur,
  input  logic [DIGIT_W-1:0]  data_in,
  output logic [DIGIT_W-1:0]  nxt
);

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = data_in;
      ACT_COUNT: nxt = bcd_advance(cur);
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/bcd_term_decode.sv
module bcd_term_decode
  import bcd_stage_pkg::*;
(
  input  logic [DIGIT_W-1:0] cur,
  input  logic               chain_en,
  output logic               term
);

  // Full compare: codes 11, 13 and 15 must not decode as terminal
  assign term = chain_en & digit_is_last(cur);

endmodule

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
  import bcd_stage_pkg::*;
(
  input  logic        clk,
  input  logic        clr_n,
  input  logic        load_n,
  input  logic [3:0]  data_in,
  input  logic        cnt_en_par,
  input  logic        cnt_en_chain,
  output logic [3:0]  count_q,
  output logic        carry_out
);

  act_t                     act;
  logic [MODE_COUNT_N-1:0]  act_vec;
  logic [DIGIT_W-1:0]       next_digit;
  logic [DIGIT_W-1:0]       digit_r;

  // Named events for the assertions
  logic clear_evt, load_evt, count_evt, hold_evt;

  bcd_action_sel u_sel (
    .clr_n        (clr_n),
    .load_n       (load_n),
    .cnt_en_par   (cnt_en_par),
    .cnt_en_chain (cnt_en_chain),
    .act          (act),
    .act_vec      (act_vec)
  );

  bcd_next_digit u_next (
    .act     (act),
    .cur     (digit_r),
    .data_in (data_in),
    .nxt     (next_digit)
  );

  bcd_term_decode u_term (
    .cur      (digit_r),
    .chain_en (cnt_en_chain),
    .term     (carry_out)
  );

  always_ff @(posedge clk) begin
    digit_r <= next_digit;
  end

  assign count_q   = digit_r;
  assign clear_evt = act_vec[0];
  assign load_evt  = act_vec[1];
  assign count_evt = act_vec[2];
  assign hold_evt  = act_vec[3];

  // R2: clear overrides every other input
  clear_to_zero_chk: assert property (@(posedge clk)
    !clr_n |=> (count_q == 4'd0));

  // R3: the load path copies the data input
  load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && !load_n) |=> (count_q == $past(data_in)));

  // R4: without both enables the digit holds
  hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
    hold_evt |=> $stable(count_q));

  // R1: nine wraps to zero when counting
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (count_evt && count_q == 4'd9) |=> (count_q == 4'd0));

  // R7: an odd non-BCD code returns to 0..9 on the next counting edge
  illegal_exit_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (count_evt && count_q > 4'd9 && count_q[0]) |=> (count_q <= 4'd9));

  // R5: the carry only rises on 9 with the chained enable
  carry_decode_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (cnt_en_chain && count_q == 4'd9));

  // R6: no carry in a non-BCD code
  carry_illegal_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (count_q > 4'd9) |-> !carry_out);

  // R4: exactly one action each cycle, and it agrees with the encoded choice
  action_onehot_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $onehot(act_vec) && (count_evt == (act == ACT_COUNT)) && (load_evt == (act == ACT_LOAD))
    && (clear_evt == (act == ACT_CLEAR)));

endmodule

// File: tb/bcd_decade_stage_tb_top.sv
module bcd_decade_stage_tb_top;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] data_lo = 4'd0;
  logic [3:0] data_hi = 4'd0;
  logic       en_par = 1'b0;
  logic       en_chain = 1'b0;
  logic [3:0] q_lo, q_hi;
  logic       carry_lo, carry_hi;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_lo, exp_hi;
  bit known = 0;

  always #5 clk = ~clk;

  bcd_decade_stage dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_lo),
    .cnt_en_par(en_par), .cnt_en_chain(en_chain),
    .count_q(q_lo), .carry_out(carry_lo)
  );

  // R8: the low digit's carry is the high digit's chained enable
  bcd_decade_stage hi_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_hi),
    .cnt_en_par(en_par), .cnt_en_chain(carry_lo),
    .count_q(q_hi), .carry_out(carry_hi)
  );

  // Reference successor: the non-BCD odd codes map to 17 - code
  function automatic logic [3:0] ref_succ(input logic [3:0] q);
    if (q == 4'd9) return 4'd0;
    if (q > 4'd9 && q[0]) return 4'(5'd17 - {1'b0, q});
    return q + 4'd1;
  endfunction

  function automatic logic [3:0] ref_step(input bit c, input bit l, input logic [3:0] d,
                                          input bit p, input bit t, input logic [3:0] q);
    if (!c) return 4'd0;
    if (!l) return d;
    if (p && t) return ref_succ(q);
    return q;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check carries, then check digits after the edge
  task automatic step(input bit c, input bit l, input bit p, input bit t,
                      input logic [3:0] dl, input logic [3:0] dh, input string req);
    logic exp_clo;
    @(negedge clk);
    clr_n = c; load_n = l; en_par = p; en_chain = t; data_lo = dl; data_hi = dh;
    #1;
    if (known) begin
      exp_clo = t && (exp_lo == 4'd9);
      check("R5/R6 low carry", {3'b0, carry_lo}, {3'b0, exp_clo});
      check("R5 high carry", {3'b0, carry_hi}, {3'b0, exp_clo && exp_hi == 4'd9});
      exp_hi = ref_step(c, l, dh, p, exp_clo, exp_hi);
      exp_lo = ref_step(c, l, dl, p, t, exp_lo);
    end else if (!c) begin
      exp_lo = 4'd0; exp_hi = 4'd0; known = 1;
    end
    @(posedge clk);
    #2;
    if (known) begin
      check({req, " low digit"}, q_lo, exp_lo);
      check({req, " high digit"}, q_hi, exp_hi);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    // R2 reset state with enables and load active
    step(0, 0, 1, 1, 4'd7, 4'd3, "R2");
    check("R2 carry after clear", {3'b0, carry_lo}, 4'd0);

    // R1 and R8: full 00..99 run and the 99->00 wrap
    for (int i = 0; i < 101; i++) step(1, 1, 1, 1, 4'd0, 4'd0, "R1/R8");

    // R4: each enable alone holds
    step(1, 1, 1, 0, 4'd0, 4'd0, "R4");
    step(1, 1, 0, 1, 4'd0, 4'd0, "R4");

    // R5: on 9, carry ignores the local enable
    step(1, 0, 1, 1, 4'd9, 4'd4, "R3");
    step(1, 1, 0, 1, 4'd0, 4'd0, "R5");
    step(1, 1, 0, 0, 4'd0, 4'd0, "R5");

    // R7 and R6: every non-BCD code loaded, then two counting edges
    for (int v = 10; v < 16; v++) begin
      step(1, 0, 0, 0, 4'(v), 4'(v), "R3");
      step(1, 1, 1, 1, 4'd0, 4'd0, "R7");
      step(1, 1, 1, 1, 4'd0, 4'd0, "R7");
    end
    // R7: clear and load still work from a non-BCD code
    step(1, 0, 1, 1, 4'd13, 4'd15, "R3");
    step(0, 0, 1, 1, 4'd5, 4'd5, "R2");
    step(1, 0, 1, 1, 4'd12, 4'd11, "R3");
    step(1, 0, 1, 1, 4'd2, 4'd8, "R3");

    // R2/R3/R4: every combination of the four controls
    for (int m = 0; m < 16; m++)
      step(m[3], m[2], m[1], m[0], 4'($urandom_range(15)), 4'($urandom_range(15)), "R2/R3/R4");

    // Weighted random run
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(99) >= 3), ($urandom_range(99) >= 6),
           ($urandom_range(99) >= 15), ($urandom_range(99) >= 15),
           4'($urandom_range(15)), 4'($urandom_range(15)), "R1/R4/R7/R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule